// File: doc/BRIEF.md
# Burst Read Initiator for a Multiplexed Parallel Bus

This block is the initiating side of a synchronous read burst on a 32-bit parallel bus. Address and data share the same lines, and every control line is active low. A local client gives a start address, a command code and a word count with a one-cycle start pulse. The block requests the bus and waits for a grant while the bus is idle. It then drives one address clock and releases the shared lines for a turnaround clock. After that it collects one word on every clock edge where both ready lines are asserted.

The client can slow the burst with a buffer-full input, which makes the block withdraw its ready line. The block signals the last word by releasing its cycle line during that final data phase. When the burst ends, it drives all of its control lines inactive for one clock and then floats them. It reports completion with a done pulse. If no target claims the cycle in time, it ends the cycle early and reports an abort.

The bus pins are split into an output value, an output enable and the resolved bus value seen as an input. This lets the pad ring or the bus model build the shared lines.

Top module: `burst_read_initiator`

## Requirements
- R1: While reset is asserted, and on leaving reset, every enable is low, `breq_n` is high, and `lcl_busy`, `lcl_valid`, `lcl_done` and `lcl_abort` are low.
- R2: A `lcl_start` sampled while idle asserts `breq_n` low on the next clock and keeps it low until the address clock, during which it is high. A `lcl_start` sampled while `lcl_busy` is high is ignored.
- R3: The address clock follows a clock edge only if that edge sees `bgnt_n` low and both `bus_cyc_n` and `bus_mrdy_n` high. Otherwise the request is held.
- R4: The address clock lasts exactly one clock. In it `cyc_oe` is high and `cyc_out_n` is low, `ad_oe` is high with `ad_out` equal to the captured address, and `cbe_out` equals the captured command.
- R5: `ad_oe` is low on every clock after the address clock. From the first data clock on, `cbe_out` is 0, meaning all byte lanes are enabled.
- R6: In the first data clock `mrdy_out_n` is low unless `lcl_full` was high at the edge that ended the address clock. During data clocks, `lcl_full` high at an edge makes `mrdy_out_n` high in the next clock.
- R7: A word is taken on every edge where `mrdy_out_n` and `srdy_n` are both low. It appears on `lcl_data` with `lcl_valid` high for exactly the following clock, in bus order.
- R8: `cyc_out_n` goes high during the data phase of the final word, and only while `mrdy_out_n` is low. Once it has gone high it stays high, and `mrdy_out_n` stays low until that word moves. A `lcl_count` of 0 is taken as one word.
- R9: After the final word, one clock follows with `cyc_oe` and `mrdy_oe` high and both driven lines high, with `lcl_done` high. On the next clock all enables are low and `lcl_busy` is low.
- R10: If `sel_n` was high at each of the first 5 edges ending data clocks, that 5th edge ends the cycle. The closing clock of R9 follows, with `lcl_abort` high alongside `lcl_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| lcl_start | input | 1 | One-cycle burst request |
| lcl_addr | input | 32 | Burst start address |
| lcl_cmd | input | 4 | Command code driven in the address clock |
| lcl_count | input | 8 | Words to read, 0 means one |
| lcl_full | input | 1 | Local buffer full, inserts initiator wait states |
| lcl_busy | output | 1 | High from request to the end of the closing clock |
| lcl_valid | output | 1 | One-cycle strobe for `lcl_data` |
| lcl_data | output | 32 | Received word |
| lcl_done | output | 1 | Burst finished, bus returning to idle |
| lcl_abort | output | 1 | No target claimed the cycle |
| breq_n | output | 1 | Bus request, active low |
| bgnt_n | input | 1 | Bus grant, active low |
| bus_cyc_n | input | 1 | Resolved cycle line |
| bus_mrdy_n | input | 1 | Resolved initiator-ready line |
| cyc_out_n | output | 1 | Cycle line value, active low |
| cyc_oe | output | 1 | Cycle line drive enable |
| mrdy_out_n | output | 1 | Initiator-ready value, active low |
| mrdy_oe | output | 1 | Initiator-ready drive enable |
| srdy_n | input | 1 | Target ready, active low |
| sel_n | input | 1 | Target claims the cycle, active low |
| ad_out | output | 32 | Address driven on the shared lines |
| ad_oe | output | 1 | Shared line drive enable |
| ad_in | input | 32 | Shared line value, read data |
| cbe_out | output | 4 | Command, then byte enables (active low) |
| cbe_oe | output | 1 | Command/byte enable drive enable |

## Verification
The bench targets the final data phase when the local buffer is full. A design that drops its cycle line while it is not ready, or that raises the cycle line again later, shows up as a cycle line or ready line mismatch on that clock. It grants the bus while another initiator still holds only the ready line. A design that checks only the cycle line would start its address clock too soon. Targets that claim the cycle on the 5th edge or later test the timeout: a counter off by one either aborts a good cycle or lets a dead one run on. Counts of 1 and 0, target wait states, and a start pulse in the middle of a burst catch errors in the early release and a second capture that should not happen.

// File: rtl/burst_read_initiator.sv
module burst_read_initiator #(
  parameter int AW = 32,
  parameter int CW = 4,
  parameter int NW = 8,
  parameter int SEL_WAIT = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lcl_start,
  input  logic [AW-1:0] lcl_addr,
  input  logic [CW-1:0] lcl_cmd,
  input  logic [NW-1:0] lcl_count,
  input  logic          lcl_full,
  output logic          lcl_busy,
  output logic          lcl_valid,
  output logic [AW-1:0] lcl_data,
  output logic          lcl_done,
  output logic          lcl_abort,
  output logic          breq_n,
  input  logic          bgnt_n,
  input  logic          bus_cyc_n,
  input  logic          bus_mrdy_n,
  output logic          cyc_out_n,
  output logic          cyc_oe,
  output logic          mrdy_out_n,
  output logic          mrdy_oe,
  input  logic          srdy_n,
  input  logic          sel_n,
  output logic [AW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [AW-1:0] ad_in,
  output logic [CW-1:0] cbe_out,
  output logic          cbe_oe
);

  localparam int TW = $clog2(SEL_WAIT + 1);

  typedef enum logic [2:0] {S_IDLE, S_REQ, S_ADDR, S_DATA, S_END} st_t;

  st_t           st;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cmd_q;
  logic [NW-1:0] left_q;
  logic          rdy_q, frm_q, seen_q, abort_q, valid_q;
  logic [TW-1:0] tmo_q;
  logic [AW-1:0] data_q;

  wire in_data  = (st == S_DATA);
  wire bus_idle = bus_cyc_n & bus_mrdy_n;
  wire xfer     = in_data & rdy_q & ~srdy_n;
  wire last     = xfer & (left_q == NW'(1));
  wire timeout  = in_data & ~seen_q & sel_n & (tmo_q == TW'(SEL_WAIT - 1)) & ~last;
  wire [NW-1:0] left_nx = left_q - {{(NW-1){1'b0}}, xfer};
  wire nrdy     = ~lcl_full | (in_data & ~frm_q);
  wire nfrm     = ~((left_nx == NW'(1)) & nrdy);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      addr_q  <= '0;
      cmd_q   <= '0;
      left_q  <= '0;
      rdy_q   <= 1'b0;
      frm_q   <= 1'b0;
      seen_q  <= 1'b0;
      abort_q <= 1'b0;
      tmo_q   <= '0;
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= xfer;
      if (xfer) data_q <= ad_in;
      case (st)
        S_IDLE: if (lcl_start) begin
          st      <= S_REQ;
          addr_q  <= lcl_addr;
          cmd_q   <= lcl_cmd;
          left_q  <= (lcl_count == '0) ? NW'(1) : lcl_count;
          abort_q <= 1'b0;
        end
        S_REQ: if (!bgnt_n && bus_idle) st <= S_ADDR;
        S_ADDR: begin
          st     <= S_DATA;
          rdy_q  <= nrdy;
          frm_q  <= nfrm;
          seen_q <= 1'b0;
          tmo_q  <= '0;
        end
        S_DATA: begin
          left_q <= left_nx;
          rdy_q  <= nrdy;
          frm_q  <= nfrm;
          if (!sel_n) seen_q <= 1'b1;
          if (!seen_q) tmo_q <= tmo_q + TW'(1);
          if (last) st <= S_END;
          else if (timeout) begin
            st      <= S_END;
            abort_q <= 1'b1;
          end
        end
        S_END: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign lcl_busy   = (st != S_IDLE);
  assign lcl_valid  = valid_q;
  assign lcl_data   = data_q;
  assign lcl_done   = (st == S_END);
  assign lcl_abort  = (st == S_END) & abort_q;
  assign breq_n     = (st != S_REQ);
  assign cyc_oe     = (st == S_ADDR) | in_data | (st == S_END);
  assign cyc_out_n  = (st == S_ADDR) ? 1'b0 : in_data ? ~frm_q : 1'b1;
  assign mrdy_oe    = in_data | (st == S_END);
  assign mrdy_out_n = in_data ? ~rdy_q : 1'b1;
  assign ad_oe      = (st == S_ADDR);
  assign ad_out     = addr_q;
  assign cbe_oe     = cyc_oe;
  assign cbe_out    = (st == S_ADDR) ? cmd_q : '0;

endmodule

// File: rtl/burst_read_initiator_checks.sv
module burst_read_initiator_checks (
  input logic clk,
  input logic rst_n,
  input logic lcl_start,
  input logic lcl_valid,
  input logic lcl_done,
  input logic lcl_abort,
  input logic breq_n,
  input logic bgnt_n,
  input logic bus_cyc_n,
  input logic bus_mrdy_n,
  input logic cyc_out_n,
  input logic cyc_oe,
  input logic mrdy_out_n,
  input logic mrdy_oe,
  input logic srdy_n,
  input logic ad_oe
);

  assert_req_from_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(breq_n) |-> $past(lcl_start));

  assert_req_not_driving_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !breq_n |-> !cyc_oe && !ad_oe);

  assert_grant_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> $past(!bgnt_n && bus_cyc_n && bus_mrdy_n));

  assert_addr_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> cyc_oe && !cyc_out_n && breq_n);

  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |=> !ad_oe);

  assert_word_handshake_R7: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_valid |-> $past(mrdy_oe && !mrdy_out_n && !srdy_n));

  assert_release_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mrdy_oe && cyc_out_n && !lcl_done) |-> !mrdy_out_n);

  assert_release_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mrdy_oe && cyc_out_n && !lcl_done) |=> cyc_out_n);

  assert_float_after_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_done |=> !cyc_oe && !mrdy_oe && !ad_oe);

  assert_abort_with_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    lcl_abort |-> lcl_done);

endmodule

bind burst_read_initiator burst_read_initiator_checks i_checks (.*);

// File: tb/test_burst_read_initiator.sv
module test_burst_read_initiator;
  localparam int AW = 32, CW = 4, NW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, lcl_start, lcl_full, bgnt_n, srdy_n, sel_n;
  logic [AW-1:0] lcl_addr, ad_in;
  logic [CW-1:0] lcl_cmd;
  logic [NW-1:0] lcl_count;
  logic lcl_busy, lcl_valid, lcl_done, lcl_abort, breq_n;
  logic [AW-1:0] lcl_data, ad_out;
  logic cyc_out_n, cyc_oe, mrdy_out_n, mrdy_oe, ad_oe, cbe_oe;
  logic [CW-1:0] cbe_out;
  logic ext_frm, ext_irdy;
  logic bus_cyc_n, bus_mrdy_n;

  assign bus_cyc_n  = cyc_oe  ? cyc_out_n  : ~ext_frm;
  assign bus_mrdy_n = mrdy_oe ? mrdy_out_n : ~ext_irdy;

  burst_read_initiator i_burst_read_initiator (.*);

  int vectors = 0, fails = 0;
  bit in_reset;
  // reference model state
  int ph = 0, m_left = 0, dk = 0, widx = 0, req_cycles = 0;
  bit m_seen, m_rdy, m_frm, m_abort, m_valid;
  logic [AW-1:0] m_addr = '0, m_data = '0;
  logic [CW-1:0] m_cmd = '0;
  // scenario
  bit start_req = 0;
  int gnt_delay = 0, sel_delay = 0, ext_frm_left = 0, ext_irdy_left = 0;
  logic [31:0] srdy_pat = '1, full_pat = '0;

  function automatic logic [AW-1:0] word_at(logic [AW-1:0] a, int i);
    return (a + AW'(i * 4)) ^ 32'hA55A_0000;
  endfunction

  task automatic chk(string tag, logic [AW-1:0] act, logic [AW-1:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: actual %h expected %h", in_reset ? "R1" : tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2 busy", AW'(lcl_busy), AW'(ph != 0));
    chk("R2/R3 breq_n", AW'(breq_n), AW'(ph != 1));
    chk("R4/R9 cyc_oe", AW'(cyc_oe), AW'(ph >= 2));
    chk("R4/R8 cyc_out_n", AW'(cyc_out_n), AW'(ph == 2 ? 1'b0 : ph == 3 ? !m_frm : 1'b1));
    chk("R6/R9 mrdy_oe", AW'(mrdy_oe), AW'(ph >= 3));
    chk("R6/R8 mrdy_out_n", AW'(mrdy_out_n), AW'(ph == 3 ? !m_rdy : 1'b1));
    chk("R4/R5 ad_oe", AW'(ad_oe), AW'(ph == 2));
    if (ph == 2) chk("R4 ad_out", ad_out, m_addr);
    chk("R5 cbe_oe", AW'(cbe_oe), AW'(ph >= 2));
    if (ph >= 2) chk("R4/R5 cbe_out", AW'(cbe_out), AW'(ph == 2 ? m_cmd : '0));
    chk("R7 lcl_valid", AW'(lcl_valid), AW'(m_valid));
    if (m_valid) chk("R7 lcl_data", lcl_data, m_data);
    chk("R9 lcl_done", AW'(lcl_done), AW'(ph == 4));
    chk("R10 lcl_abort", AW'(lcl_abort), AW'(ph == 4 && m_abort));
  endtask

  task automatic step();
    bit xf, to, full;
    @(negedge clk);
    compare_all();
    lcl_start = start_req;
    start_req = 0;
    ext_frm  = (ext_frm_left > 0);
    ext_irdy = (ext_irdy_left > 0);
    if (ext_frm_left > 0) ext_frm_left--;
    if (ext_irdy_left > 0) ext_irdy_left--;
    bgnt_n = !(ph == 1 && req_cycles >= gnt_delay);
    sel_n  = !(ph == 3 && dk >= sel_delay);
    srdy_n = !(ph == 3 && dk >= sel_delay && srdy_pat[dk % 32]);
    ad_in  = (ph == 3) ? word_at(m_addr, widx) : '0;
    full   = (ph == 2) ? full_pat[0] : (ph == 3) ? full_pat[(dk + 1) % 32] : 1'b0;
    lcl_full = full;
    if (in_reset) return;
    m_valid = 0;
    case (ph)
      0: if (lcl_start) begin
        ph = 1; m_addr = lcl_addr; m_cmd = lcl_cmd;
        m_left = (lcl_count == 0) ? 1 : int'(lcl_count);
        m_abort = 0; req_cycles = 0; widx = 0;
      end
      1: if (!bgnt_n && !ext_frm && !ext_irdy) ph = 2; else req_cycles++;
      2: begin
        ph = 3; dk = 0; m_seen = 0;
        m_rdy = !full; m_frm = !(m_left == 1 && m_rdy);
      end
      3: begin
        xf = m_rdy && !srdy_n;
        to = !m_seen && sel_n && dk == 4;
        if (!sel_n) m_seen = 1;
        if (xf) begin m_valid = 1; m_data = ad_in; m_left--; widx++; end
        if (xf && m_left == 0) ph = 4;
        else if (to) begin ph = 4; m_abort = 1; end
        else begin
          m_rdy = !full || !m_frm;
          m_frm = !(m_left == 1 && m_rdy);
          dk++;
        end
      end
      default: ph = 0;
    endcase
  endtask

  task automatic run_burst(logic [AW-1:0] a, logic [CW-1:0] c, int n, int poke);
    lcl_addr = a; lcl_cmd = c; lcl_count = NW'(n);
    start_req = 1;
    step();
    for (int i = 0; i < 300 && ph != 0; i++) begin
      if (i == poke) begin
        start_req = 1; lcl_addr = 32'hDEAD_0000; lcl_count = 8'd9;
      end
      step();
    end
    for (int i = 0; i < 3; i++) step();
    gnt_delay = 0; sel_delay = 0; srdy_pat = '1; full_pat = '0;
  endtask

  initial begin
    #(200000 * 10);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    rst_n = 0; in_reset = 1;
    lcl_start = 0; lcl_full = 0; bgnt_n = 1; srdy_n = 1; sel_n = 1;
    lcl_addr = '0; lcl_cmd = '0; lcl_count = '0; ad_in = '0;
    ext_frm = 0; ext_irdy = 0;
    // R1: reset state
    for (int i = 0; i < 3; i++) step();
    rst_n = 1;
    step();
    in_reset = 0;
    // R4 R5 R7 R9: plain four-word burst, R2: start during the burst is ignored
    sel_delay = 1;
    run_burst(32'h1000_0000, 4'h6, 4, 3);
    // R6 R7: target and initiator wait states
    srdy_pat = 32'hFFFF_FFB6; full_pat = 32'h0000_0029;
    run_burst(32'h2000_0040, 4'hC, 5, -1);
    // R8: single word and a zero count
    run_burst(32'h3000_0100, 4'h6, 1, -1);
    full_pat = 32'h1;
    run_burst(32'h3000_0200, 4'h6, 0, -1);
    // R8: buffer full across the last data phase
    full_pat = 32'h6; srdy_pat = 32'hFFFF_FFFD;
    run_burst(32'h4000_0000, 4'hE, 2, -1);
    // R3: late grant, other initiator holding the cycle line then only the ready line
    gnt_delay = 3; ext_frm_left = 4; ext_irdy_left = 8;
    run_burst(32'h5000_0010, 4'h6, 3, -1);
    // R10: claim on the 5th edge is accepted
    sel_delay = 4;
    run_burst(32'h6000_0000, 4'h6, 3, -1);
    // R10: claim too late, then no claim at all
    sel_delay = 5;
    run_burst(32'h7000_0000, 4'h6, 3, -1);
    sel_delay = 1000;
    run_burst(32'h7100_0000, 4'h6, 2, -1);
    // R7 R8: long burst with mixed waits
    srdy_pat = 32'hDF7B_EFF7; full_pat = 32'h2104_0810;
    run_burst(32'h8000_0000, 4'h7, 40, 10);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule